// File: doc/BRIEF.md
# Widening Signed Add/Subtract Unit

This block adds or subtracts two 3-bit two's complement operands. The datapath is a ripple chain of three full-adder cells. One mode input selects the operation: 0 adds and 1 subtracts. In subtract mode every bit of B is inverted before it enters its cell, and the mode bit also feeds the carry-in of the lowest cell.

The block exposes its internal signals: the three raw sum bits, the carry-out of each cell and an overflow flag for the 3-bit range. It also gives a 4-bit result that always holds the exact signed value. The fourth bit is taken from the top carry-out when the narrow result overflows, and from the top sum bit otherwise. The unit is purely combinational and has no clock or reset.

Top module: `addsub_widen_unit`

## Requirements
- R1: `sum_raw` equals the low three bits of A + B (mode 0) or A - B (mode 1), taken modulo 8.
- R2: `carry_vec[i]` is the carry out of cell i. It is 1 exactly when the unsigned sum of the low i+1 bits of A, the low i+1 bits of (B XOR mode replicated) and the mode bit reaches 2^(i+1).
- R3: `ovf` is 1 exactly when the true signed result lies outside -4..+3.
- R4: `result`, read as a 4-bit two's complement number, equals the exact signed value of A + B or A - B for all 64 operand pairs in both modes, covering -8..+7.
- R5: `result[2:0]` always equals `sum_raw`.
- R6: `result[3]` equals `carry_vec[2]` while `ovf` is 1, and equals `sum_raw[2]` while `ovf` is 0.
- R7: In subtract mode with B = 0, the carry vector is 3'b111 and the result equals A sign-extended.
- R8: With all inputs zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 3 | Operand A, two's complement |
| op_b | input | 3 | Operand B, two's complement |
| sub_mode | input | 1 | 0 = add, 1 = subtract; also the carry-in of cell 0 |
| sum_raw | output | 3 | Sum bits of the three cells |
| carry_vec | output | 3 | Carry-out of each cell, bit i from cell i |
| ovf | output | 1 | Overflow of the 3-bit signed range |
| result | output | 4 | Exact widened two's complement result |

## Verification
The unit is tried with every operand pair in both modes, which separates positive overflow (for example 3+3 or 3-(-4)) from negative overflow (for example -4+-4 or -4-1). It also separates these from in-range results, where the top bit must copy the sign instead of the carry. Subtracting zero drives a carry through every cell, which shows whether the mode bit really reaches the lowest carry-in and whether B is inverted. Comparing each carry bit on its own, not just the final sum, shows whether a single cell has its carry logic miswired.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef struct packed {
    logic s;
    logic c;
  } fa_out_t;

  // One-bit full addition: sum and carry of three input bits.
  function automatic fa_out_t fa_eval(input logic a, input logic b, input logic ci);
    fa_out_t r;
    r.s = a ^ b ^ ci;
    r.c = (a & b) | (ci & (a ^ b));
    return r;
  endfunction

  // Signed overflow: the carry into the sign cell differs from the carry out of it.
  function automatic logic ovf_from_carries(input logic c_top, input logic c_below);
    return c_top ^ c_below;
  endfunction

  // Extra sign bit for the widened result.
  function automatic logic widen_msb(input logic ovf, input logic c_top, input logic s_top);
    return ovf ? c_top : s_top;
  endfunction

endpackage

// File: rtl/addsub_fa_cell.sv
module addsub_fa_cell
  import addsub_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  input  logic c_in,
  output logic s_bit,
  output logic c_out
);

  fa_out_t res;

  always_comb begin
    res   = fa_eval(a_bit, b_bit, c_in);
    s_bit = res.s;
    c_out = res.c;
  end

endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             mode,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] carry_o
);

  logic [WIDTH-1:0] b_cond;
  logic [WIDTH:0]   chain;

  // Invert B in subtract mode; the mode bit supplies the +1.
  assign b_cond   = b_in ^ {WIDTH{mode}};
  assign chain[0] = mode;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    addsub_fa_cell u_cell (
      .a_bit (a_in[i]),
      .b_bit (b_cond[i]),
      .c_in  (chain[i]),
      .s_bit (sum_o[i]),
      .c_out (chain[i+1])
    );
  end

  assign carry_o = chain[WIDTH:1];

endmodule

// File: rtl/addsub_widen.sv
module addsub_widen
  import addsub_pkg::*;
#(
  parameter int WIDTH = 3,
  localparam int RES_W = WIDTH + 1
) (
  input  logic [WIDTH-1:0] sum_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic             ovf_o,
  output logic [RES_W-1:0] res_o
);

  logic msb;

  always_comb begin
    ovf_o = ovf_from_carries(carry_i[WIDTH-1], carry_i[WIDTH-2]);
    msb   = widen_msb(ovf_o, carry_i[WIDTH-1], sum_i[WIDTH-1]);
    res_o = {msb, sum_i};
  end

endmodule

// File: rtl/addsub_widen_unit.sv
module addsub_widen_unit #(
  parameter int WIDTH = 3,
  localparam int RES_W = WIDTH + 1
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] sum_raw,
  output logic [WIDTH-1:0] carry_vec,
  output logic             ovf,
  output logic [RES_W-1:0] result
);

  logic [WIDTH-1:0] sum_w;
  logic [WIDTH-1:0] carry_w;

  addsub_ripple #(.WIDTH(WIDTH)) u_ripple (
    .a_in    (op_a),
    .b_in    (op_b),
    .mode    (sub_mode),
    .sum_o   (sum_w),
    .carry_o (carry_w)
  );

  addsub_widen #(.WIDTH(WIDTH)) u_widen (
    .sum_i   (sum_w),
    .carry_i (carry_w),
    .ovf_o   (ovf),
    .res_o   (result)
  );

  assign sum_raw   = sum_w;
  assign carry_vec = carry_w;

endmodule

// File: rtl/addsub_widen_chk.sv
module addsub_widen_chk #(
  parameter int WIDTH = 3,
  localparam int RES_W = WIDTH + 1
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             sub_mode,
  input logic [WIDTH-1:0] sum_raw,
  input logic [WIDTH-1:0] carry_vec,
  input logic             ovf,
  input logic [RES_W-1:0] result
);

  logic [RES_W-1:0] a_ext;
  logic [RES_W-1:0] b_ext;
  logic [RES_W-1:0] exact;

  always_comb begin
    a_ext = {op_a[WIDTH-1], op_a};
    b_ext = {op_b[WIDTH-1], op_b};
    exact = sub_mode ? (a_ext - b_ext) : (a_ext + b_ext);

    a_r4_exact_value: assert (result == exact)
      else $error("a_r4_exact_value");
    a_r5_low_bits: assert (result[WIDTH-1:0] == sum_raw)
      else $error("a_r5_low_bits");
    a_r3_no_overflow: assert (ovf == (result[RES_W-1] != result[WIDTH-1]))
      else $error("a_r3_no_overflow");
    a_r2_cell0_carry: assert (carry_vec[0] ==
        ((op_a[0] & (op_b[0] ^ sub_mode)) | (sub_mode & (op_a[0] | (op_b[0] ^ sub_mode)))))
      else $error("a_r2_cell0_carry");
    if (sub_mode && op_b == '0) begin
      a_r7_sub_zero_carries: assert (carry_vec == '1)
        else $error("a_r7_sub_zero_carries");
    end
  end

endmodule

bind addsub_widen_unit addsub_widen_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .sub_mode  (sub_mode),
  .sum_raw   (sum_raw),
  .carry_vec (carry_vec),
  .ovf       (ovf),
  .result    (result)
);

// File: tb/addsub_widen_unit_test.sv
module addsub_widen_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_a = '0;
  logic [2:0] op_b = '0;
  logic       sub_mode = 1'b0;
  logic [2:0] sum_raw;
  logic [2:0] carry_vec;
  logic       ovf;
  logic [3:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] a;
    logic [2:0] b;
    logic       m;
    logic [2:0] sum;
    logic [2:0] cv;
    logic       ov;
    logic [3:0] res;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  addsub_widen_unit uut (
    .op_a      (op_a),
    .op_b      (op_b),
    .sub_mode  (sub_mode),
    .sum_raw   (sum_raw),
    .carry_vec (carry_vec),
    .ovf       (ovf),
    .result    (result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v,
                     input exp_t e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d m=%0d actual=%0d expected=%0d",
               req, e.a, e.b, e.m, act, exp_v);
    end
  endtask

  // Driver: apply a stimulus and push the expected item computed from the requirements.
  task automatic drive(input logic [2:0] a, input logic [2:0] b, input logic m);
    exp_t e;
    int av, bv, ex, bx, ai, bi;
    @(posedge clk);
    #1;
    op_a = a; op_b = b; sub_mode = m;
    av = a[2] ? int'(a) - 8 : int'(a);
    bv = b[2] ? int'(b) - 8 : int'(b);
    ex = m ? av - bv : av + bv;
    bx = int'(b ^ {3{m}});
    e.a = a; e.b = b; e.m = m;
    e.sum = 3'((int'(a) + bx + int'(m)) & 7);
    for (int i = 0; i < 3; i++) begin
      ai = int'(a) & ((1 << (i + 1)) - 1);
      bi = bx & ((1 << (i + 1)) - 1);
      e.cv[i] = ((ai + bi + int'(m)) >> (i + 1)) != 0;
    end
    e.ov  = (ex < -4) || (ex > 3);
    e.res = 4'(ex & 15);
    sb.push_back(e);
  endtask

  // Monitor: compare on the falling edge after each stimulus.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(sum_raw == e.sum, "R1 sum bits", int'(sum_raw), int'(e.sum), e);
        chk(carry_vec == e.cv, "R2 carry vector", int'(carry_vec), int'(e.cv), e);
        chk(ovf == e.ov, "R3 overflow", int'(ovf), int'(e.ov), e);
        chk(result == e.res, "R4 exact result", int'(result), int'(e.res), e);
        chk(result[2:0] == sum_raw, "R5 low bits", int'(result[2:0]), int'(sum_raw), e);
        chk(result[3] == (e.ov ? e.cv[2] : e.sum[2]), "R6 msb select",
            int'(result[3]), int'(e.ov ? e.cv[2] : e.sum[2]), e);
        if (e.m && e.b == 3'd0) begin
          chk(carry_vec == 3'b111, "R7 subtract zero carries", int'(carry_vec), 7, e);
          chk(result == {e.a[2], e.a}, "R7 subtract zero value", int'(result),
              int'({e.a[2], e.a}), e);
        end
      end
    end
  end

  initial begin
    exp_t z;
    z.a = 0; z.b = 0; z.m = 0; z.sum = 0; z.cv = 0; z.ov = 0; z.res = 0;
    #3;
    // R8: all-zero inputs give all-zero outputs
    chk({sum_raw, carry_vec, ovf, result} == '0, "R8 zero state",
        int'({sum_raw, carry_vec, ovf, result}), 0, z);
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // R4/R3 named corners first
    drive(3'b011, 3'b011, 1'b0);   // 3+3 = 6, positive overflow
    drive(3'b100, 3'b100, 1'b0);   // -4+-4 = -8, negative overflow
    drive(3'b011, 3'b100, 1'b1);   // 3-(-4) = 7
    drive(3'b100, 3'b001, 1'b1);   // -4-1 = -5
    drive(3'b010, 3'b000, 1'b1);   // R7 subtract zero
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          drive(3'(a), 3'(b), 1'(m));
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule